// File: doc/BRIEF.md
# Phase-Frequency Detector with Tri-State Error Output

This block compares the rising edges of a reference pulse train with those of a divided feedback pulse train, both sampled in the system clock domain. A reference edge raises an up request and a feedback edge raises a down request. Both requests are active-low at the ports. When both requests are pending they are held together for a fixed delay and then released together. This is the usual reset path of a phase-frequency detector. It also gives each request a minimum width.

The requests drive one three-state error pin, modelled as a data bit and an output enable. A lone up request means the reference leads, and the pin is driven low. A lone down request means the feedback leads, and the pin is driven high. With no request or both requests pending, the pin floats. The delay is given in nanoseconds and turned into a count of system clocks at elaboration time. The number of synchroniser flops on each input is a parameter.

Top module: `phase_lead_detector`

## Requirements
- R1: A synchronous active-high `rst` clears both requests (`up_n`=1, `dn_n`=1) and floats the error pin (`err_oe`=0) on the next clock edge.
- R2: A rising edge on `ref_in` pulls `up_n` low. With SYNC_STAGES=2 this happens on the third clock edge after the input changes. A held high level or a falling edge raises no further request.
- R3: A rising edge on `fb_in` pulls `dn_n` low with the same latency as R2, under the same edge-only rule.
- R4: While only the up request is active (`up_n`=0, `dn_n`=1), `err_oe`=1 and `err_data`=0.
- R5: While only the down request is active (`up_n`=1, `dn_n`=0), `err_oe`=1 and `err_data`=1.
- R6: While neither or both requests are active, `err_oe`=0.
- R7: Once both requests are active, both stay active for exactly HOLD_CYC clocks and then clear on the same edge. HOLD_CYC = ceil(CLK_MHZ*DELAY_NS/1000), and it is at least 1.
- R8: A new edge whose request would be set on the same edge that the pair clears wins, and that request stays active.
- R9: A single request stays active indefinitely until the opposite edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse train, edge-sampled |
| fb_in | input | 1 | Divided feedback pulse train, edge-sampled |
| up_n | output | 1 | Up request, active low |
| dn_n | output | 1 | Down request, active low |
| err_data | output | 1 | Level driven on the error pin when enabled |
| err_oe | output | 1 | Error pin output enable, 0 = high impedance |

## Verification
An input change made between clock edges reaches a request output on the third rising edge that follows. This comes from two synchroniser flops and the request register. The error pin follows the requests with no added cycle. A paired release comes HOLD_CYC edges after the later request is set. The bench drives and samples only on falling edges. Each pulse-pair trial counts how many falling-edge samples show each request active and the pin enabled. These counts are compared with the gap between the two pulses plus HOLD_CYC, for every gap from zero to beyond the hold window, in both orders. The set-wins case is timed so that its edge meets the clearing edge exactly.

// File: rtl/pld_pkg.sv
package pld_pkg;

   // Clocks needed to cover a delay in ns at a clock in MHz, rounded up.
   function automatic int unsigned hold_cycles(input int unsigned mhz, input int unsigned ns);
      return (mhz * ns + 999) / 1000;
   endfunction

   // Error pin state packed as {output_enable, data}.
   typedef enum logic [1:0] {
      PIN_FLOAT = 2'b00,
      PIN_LOW   = 2'b10,
      PIN_HIGH  = 2'b11
   } pin_state_e;

endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);

   logic level;
   logic level_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) begin
               chain <= '0;
            end else begin
               chain[0] <= din;
               for (int i = 1; i < int'(STAGES); i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign level = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) level_q <= 1'b0;
      else     level_q <= level;
   end

   assign rise = level & ~level_q;

endmodule

// File: rtl/pld_req_core.sv
module pld_req_core #(
   parameter int unsigned HOLD_CYC = 4,
   localparam int unsigned CW = $clog2(HOLD_CYC + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_rise,
   input  logic fb_rise,
   output logic up_req,
   output logic dn_req
);

   logic [CW-1:0] hold_cnt;
   logic          pair;
   logic          release_now;

   assign pair        = up_req & dn_req;
   assign release_now = pair && (hold_cnt == CW'(HOLD_CYC - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         up_req   <= 1'b0;
         dn_req   <= 1'b0;
         hold_cnt <= '0;
      end else begin
         // A fresh edge wins over the pair release.
         up_req <= (up_req & ~release_now) | ref_rise;
         dn_req <= (dn_req & ~release_now) | fb_rise;
         if (pair && !release_now) hold_cnt <= hold_cnt + 1'b1;
         else                      hold_cnt <= '0;
      end
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!up_req && !dn_req));
   assert_up_after_edge_R2: assert property (@(posedge clk) disable iff (rst)
      ref_rise |=> up_req);
   assert_dn_after_edge_R3: assert property (@(posedge clk) disable iff (rst)
      fb_rise |=> dn_req);
   assert_up_drops_in_pair_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(up_req) |-> $past(dn_req));
   assert_dn_drops_in_pair_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(dn_req) |-> $past(up_req));
   assert_hold_bound_R7: assert property (@(posedge clk) disable iff (rst)
      hold_cnt < CW'(HOLD_CYC));
   assert_single_persists_R9: assert property (@(posedge clk) disable iff (rst)
      (up_req && !dn_req) |=> up_req);

endmodule

// File: rtl/pld_pin_drive.sv
module pld_pin_drive (
   input  logic up_req,
   input  logic dn_req,
   output logic pin_data,
   output logic pin_oe
);
   import pld_pkg::*;

   pin_state_e state;

   always_comb begin
      unique case ({up_req, dn_req})
         2'b10:   state = PIN_LOW;
         2'b01:   state = PIN_HIGH;
         default: state = PIN_FLOAT;
      endcase
   end

   assign {pin_oe, pin_data} = state;

endmodule

// File: rtl/phase_lead_detector.sv
module phase_lead_detector #(
   parameter int unsigned CLK_MHZ     = 125,
   parameter int unsigned DELAY_NS    = 900,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_in,
   input  logic fb_in,
   output logic up_n,
   output logic dn_n,
   output logic err_data,
   output logic err_oe
);

   localparam int unsigned HOLD_CYC = pld_pkg::hold_cycles(CLK_MHZ, DELAY_NS);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("phase_lead_detector: hold delay rounds to zero clocks");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("phase_lead_detector: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic ref_rise, fb_rise;
   logic up_req, dn_req;

   pld_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst(rst), .din(ref_in), .rise(ref_rise));

   pld_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
      .clk(clk), .rst(rst), .din(fb_in), .rise(fb_rise));

   pld_req_core #(.HOLD_CYC(HOLD_CYC)) u_core (
      .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
      .up_req(up_req), .dn_req(dn_req));

   pld_pin_drive u_pin (
      .up_req(up_req), .dn_req(dn_req),
      .pin_data(err_data), .pin_oe(err_oe));

   assign up_n = ~up_req;
   assign dn_n = ~dn_req;

   assert_lead_low_R4: assert property (@(posedge clk) disable iff (rst)
      (!up_n && dn_n) |-> (err_oe && !err_data));
   assert_lag_high_R5: assert property (@(posedge clk) disable iff (rst)
      (up_n && !dn_n) |-> (err_oe && err_data));
   assert_float_R6: assert property (@(posedge clk) disable iff (rst)
      (up_n == dn_n) |-> !err_oe);

endmodule

// File: tb/phase_lead_detector_bench.sv
module phase_lead_detector_bench;

   localparam int DELAY_NS = 40;
   localparam int HOLD     = DELAY_NS / 8;   // 8 ns clock period

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_in = 1'b0;
   logic fb_in = 1'b0;
   logic up_n, dn_n, err_data, err_oe;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   phase_lead_detector #(.CLK_MHZ(125), .DELAY_NS(DELAY_NS), .SYNC_STAGES(2)) u_phase_lead_detector (
      .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
      .up_n(up_n), .dn_n(dn_n), .err_data(err_data), .err_oe(err_oe));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // One trial: first pulse on lead input at t=0, second on the other at t=gap.
   task automatic pair_trial(input int gap, input bit ref_first);
      int up_lo = 0, dn_lo = 0, oe_hi = 0, bad_pol = 0;
      for (int t = 0; t < gap + HOLD + 10; t++) begin
         @(negedge clk);
         if (!up_n) up_lo++;
         if (!dn_n) dn_lo++;
         if (err_oe) begin
            oe_hi++;
            if (err_data != (ref_first ? 1'b0 : 1'b1)) bad_pol++;
         end
         ref_in = ref_first ? (t == 0) : (t == gap);
         fb_in  = ref_first ? (t == gap) : (t == 0);
      end
      ref_in = 1'b0; fb_in = 1'b0;
      if (ref_first) begin
         check(up_lo == gap + HOLD, "R7", $sformatf("up width gap=%0d", gap), up_lo, gap + HOLD);
         check(dn_lo == HOLD, "R7", $sformatf("dn width gap=%0d", gap), dn_lo, HOLD);
         check(bad_pol == 0, "R4", $sformatf("low polarity gap=%0d", gap), bad_pol, 0);
      end else begin
         check(dn_lo == gap + HOLD, "R7", $sformatf("dn width gap=%0d", gap), dn_lo, gap + HOLD);
         check(up_lo == HOLD, "R7", $sformatf("up width gap=%0d", gap), up_lo, HOLD);
         check(bad_pol == 0, "R5", $sformatf("high polarity gap=%0d", gap), bad_pol, 0);
      end
      check(oe_hi == gap, "R6", $sformatf("enabled cycles gap=%0d", gap), oe_hi, gap);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      check(up_n == 1 && dn_n == 1, "R1", "requests idle after reset", {up_n, dn_n}, 3);
      check(err_oe == 0, "R1", "pin floats after reset", err_oe, 0);

      // Latency of a lone reference edge (R2) and lone drive low (R4).
      ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
      @(negedge clk);
      check(up_n == 1, "R2", "up not yet set after two edges", up_n, 1);
      @(negedge clk);
      check(up_n == 0, "R2", "up set on third edge", up_n, 0);
      check(err_oe == 1 && err_data == 0, "R4", "pin low with lone up",
            {err_oe, err_data}, 2);
      repeat (60) @(negedge clk);
      check(up_n == 0 && err_oe == 1, "R9", "lone up persists", {up_n, err_oe}, 1);
      fb_in = 1'b1;
      @(negedge clk); fb_in = 1'b0;
      @(negedge clk);
      check(dn_n == 1, "R3", "dn not yet set after two edges", dn_n, 1);
      @(negedge clk);
      check(dn_n == 0 && up_n == 0, "R3", "dn set on third edge", {up_n, dn_n}, 0);
      check(err_oe == 0, "R6", "pin floats with both requests", err_oe, 0);
      repeat (HOLD + 2) @(negedge clk);
      check(up_n == 1 && dn_n == 1, "R7", "pair released", {up_n, dn_n}, 3);

      // Lone down request drives high and persists.
      fb_in = 1'b1;
      @(negedge clk); fb_in = 1'b0;
      repeat (2) @(negedge clk);
      check(dn_n == 0 && err_oe == 1 && err_data == 1, "R5", "pin high with lone dn",
            {dn_n, err_oe, err_data}, 3);
      repeat (60) @(negedge clk);
      check(dn_n == 0, "R9", "lone dn persists", dn_n, 0);
      do_reset();
      @(negedge clk);
      check(dn_n == 1 && err_oe == 0, "R1", "reset mid request", {dn_n, err_oe}, 2);

      // Gap sweep in both orders.
      for (int g = 0; g <= HOLD + 4; g++) begin
         pair_trial(g, 1'b1);
         pair_trial(g, 1'b0);
      end

      // Set wins over release (R8).
      for (int t = 0; t <= HOLD + 3; t++) begin
         @(negedge clk);
         if (t == HOLD + 3) begin
            check(up_n == 0 && dn_n == 1, "R8", "new up survives release", {up_n, dn_n}, 1);
            check(err_oe == 1 && err_data == 0, "R8", "pin low after set-wins",
                  {err_oe, err_data}, 2);
         end
         ref_in = (t == 0) || (t == HOLD);
         fb_in  = (t == 0);
      end
      ref_in = 1'b0; fb_in = 1'b0;
      do_reset();

      // Held level and falling edge raise nothing new (R2).
      begin
         int up_lo = 0;
         for (int t = 0; t < HOLD + 40; t++) begin
            @(negedge clk);
            if (!up_n) up_lo++;
            ref_in = 1'b1;
            fb_in  = (t == 0);
         end
         ref_in = 1'b0;
         for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (!up_n) up_lo++;
         end
         check(up_lo == HOLD, "R2", "held level gives one request", up_lo, HOLD);
         check(err_oe == 0, "R6", "idle after falling edge", err_oe, 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule